// File: doc/BRIEF.md
# Virtual Circuit Label Swap Forwarder

This block sits in the data path of a virtual-circuit cell switch. Each arriving cell is tagged with the port it came in on and the circuit identifier (VCI) carried in its header. The block joins the two into one lookup key and reads a circuit table. A matching entry gives the egress port and the identifier the cell must carry on the next hop. The cell leaves with its identifier replaced and tagged with that egress port. Because the key includes the arrival port, the same identifier on two different ports names two unrelated circuits.

The circuit table is filled and cleared through a separate configuration port. An external signaling controller drives this port when it sets up or tears down a circuit, before any data uses that circuit. The table is a directly indexed memory addressed by the concatenation {arrival port, VCI}, with one valid flag per entry. A cell whose entry is not valid is discarded and counted. Forwarded cells appear a fixed two cycles after arrival and keep their arrival order. One cell can be accepted every cycle.

Top module: `vcsw_label_swap`

## Requirements
- R1: After reset `out_valid` is 0, `drop_count` is 0 and every table entry is invalid, so the first cell that arrives is dropped.
- R2: A cell accepted in clock cycle k whose entry is valid appears with `out_valid` = 1 in cycle k+2, and `out_port` holds the egress port stored in the entry.
- R3: A forwarded cell carries the entry's outgoing VCI on `out_vci`, and its `out_data` equals the arriving `in_data`.
- R4: The lookup key is {in_port, in_vci}, so an identical VCI arriving on different ports selects separate entries.
- R5: A cell that finds no valid entry produces no output cycle, and `drop_count` rises by one in cycle k+2.
- R6: A configuration write with `cfg_clear` = 1 invalidates the addressed entry, so later cells with that key are dropped.
- R7: A configuration write issued in the same cycle a cell arrives is not seen by that cell, which uses the old contents. Cells arriving in any later cycle use the new contents.
- R8: Cells accepted in consecutive cycles leave in consecutive cycles, in arrival order. A dropped cell leaves a one-cycle gap in its slot.
- R9: `drop_count` saturates at its all-ones value and stays there on further drops.
- R10: A configuration write with `cfg_clear` = 0 to an entry that is already valid replaces its egress port and outgoing VCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is presented this cycle |
| in_port | input | PORT_W | Arrival port of the cell |
| in_vci | input | VCI_W | Circuit identifier in the cell header |
| in_data | input | DATA_W | Cell payload |
| cfg_we | input | 1 | Table write strobe |
| cfg_clear | input | 1 | With `cfg_we`: 1 invalidates the entry, 0 installs it |
| cfg_in_port | input | PORT_W | Arrival port part of the key being written |
| cfg_in_vci | input | VCI_W | VCI part of the key being written |
| cfg_out_port | input | PORT_W | Egress port to store |
| cfg_out_vci | input | VCI_W | Outgoing VCI to store |
| out_valid | output | 1 | A forwarded cell is presented this cycle |
| out_port | output | PORT_W | Egress port of the cell |
| out_vci | output | VCI_W | Rewritten circuit identifier |
| out_data | output | DATA_W | Cell payload |
| drop_count | output | CNT_W | Saturating count of dropped cells |

## Verification
A corrupt valid flag shows up two cycles after the next cell that uses that key. The cell is either lost and counted, or sent out when it should have been dropped, and `drop_count` moves the wrong way in the same cycle. A wrong stored port or VCI, or a key that ignores the arrival port, appears on `out_port` or `out_vci` for the very cell that reads the entry. A pipeline slip appears as a cell leaving one cycle early or late, or as two streamed cells swapped. A write that leaks into a cell already in flight gives the new identifier on the cell that arrived in the write cycle.

// File: rtl/vcsw_pkg.sv
package vcsw_pkg;

  // What happens to a cell once its lookup result is known
  typedef enum logic [1:0] {
    CELL_NONE = 2'd0,
    CELL_FWD  = 2'd1,
    CELL_DROP = 2'd2
  } cell_disp_e;

  function automatic cell_disp_e classify(input logic present, input logic hit);
    if (!present) return CELL_NONE;
    return hit ? CELL_FWD : CELL_DROP;
  endfunction

endpackage

// File: rtl/vcsw_circuit_table.sv
module vcsw_circuit_table #(
  parameter int NUM_PORTS = 4,
  parameter int VCI_W     = 6,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_clear,
  input  logic [PORT_W-1:0] wr_in_port,
  input  logic [VCI_W-1:0]  wr_in_vci,
  input  logic [PORT_W-1:0] wr_out_port,
  input  logic [VCI_W-1:0]  wr_out_vci,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [VCI_W-1:0]  rd_vci,
  output logic              rd_hit,
  output logic [PORT_W-1:0] rd_out_port,
  output logic [VCI_W-1:0]  rd_out_vci
);

  localparam int KEY_W   = PORT_W + VCI_W;
  localparam int DEPTH   = 1 << KEY_W;
  localparam int ENTRY_W = PORT_W + VCI_W;

  function automatic logic [KEY_W-1:0] make_key(input logic [PORT_W-1:0] p,
                                                input logic [VCI_W-1:0]  v);
    return {p, v};
  endfunction

  logic [KEY_W-1:0]   wr_key;
  logic [KEY_W-1:0]   rd_key;
  logic [DEPTH-1:0]   entry_valid;
  logic [ENTRY_W-1:0] route_mem [DEPTH];

  assign wr_key = make_key(wr_in_port, wr_in_vci);
  assign rd_key = make_key(rd_port, rd_vci);

  // Route words: written only on install, never reset
  always_ff @(posedge clk) begin
    if (wr_en && !wr_clear) route_mem[wr_key] <= {wr_out_port, wr_out_vci};
  end

  // One valid flag per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n)                                       entry_valid[g] <= 1'b0;
      else if (wr_en && (wr_key == KEY_W'(g)))          entry_valid[g] <= !wr_clear;
    end
  end

  // Combinational read sees contents before this cycle's write
  assign rd_hit = entry_valid[rd_key];
  assign {rd_out_port, rd_out_vci} = route_mem[rd_key];

  // R6: a clear leaves the entry reading as a miss on the next cycle
  a_r6_clear_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clear && !($past(wr_en) === 1'b0 ? 1'b0 : 1'b0)) |=>
      (!wr_en || wr_key != $past(wr_key)) -> !entry_valid[$past(wr_key)]);

  // R10: an install is readable with its new route one cycle later
  a_r10_install_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_clear) |=>
      (route_mem[$past(wr_key)] == {$past(wr_out_port), $past(wr_out_vci)}));

endmodule

// File: rtl/vcsw_lookup_stage.sv
module vcsw_lookup_stage
  import vcsw_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int VCI_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              tbl_hit,
  input  logic [PORT_W-1:0] tbl_port,
  input  logic [VCI_W-1:0]  tbl_vci,
  input  logic [DATA_W-1:0] in_data,
  output cell_disp_e        s1_disp,
  output logic [PORT_W-1:0] s1_port,
  output logic [VCI_W-1:0]  s1_vci,
  output logic [DATA_W-1:0] s1_data
);

  cell_disp_e disp_now;
  assign disp_now = classify(in_valid, tbl_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) s1_disp <= CELL_NONE;
    else        s1_disp <= disp_now;
  end

  // Payload and route captured with the lookup result
  always_ff @(posedge clk) begin
    if (disp_now == CELL_FWD) begin
      s1_port <= tbl_port;
      s1_vci  <= tbl_vci;
      s1_data <= in_data;
    end
  end

endmodule

// File: rtl/vcsw_egress_stage.sv
module vcsw_egress_stage
  import vcsw_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int VCI_W  = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cell_disp_e        s1_disp,
  input  logic [PORT_W-1:0] s1_port,
  input  logic [VCI_W-1:0]  s1_vci,
  input  logic [DATA_W-1:0] s1_data,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic [VCI_W-1:0]  out_vci,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  drop_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump_sat(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic fwd_evt;
  logic drop_evt;
  assign fwd_evt  = (s1_disp == CELL_FWD);
  assign drop_evt = (s1_disp == CELL_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      drop_count <= '0;
    end else begin
      out_valid  <= fwd_evt;
      if (drop_evt) drop_count <= bump_sat(drop_count);
    end
  end

  always_ff @(posedge clk) begin
    if (fwd_evt) begin
      out_port <= s1_port;
      out_vci  <= s1_vci;
      out_data <= s1_data;
    end
  end

  // R5: each drop below the ceiling adds exactly one
  a_r5_drop_counts_one: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && drop_count != CNT_MAX) |=> (drop_count == $past(drop_count) + 1'b1));

  // R9: the counter never leaves its ceiling
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));

  // R5: without a drop the counter holds
  a_r5_count_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_count));

endmodule

// File: rtl/vcsw_label_swap.sv
module vcsw_label_swap
  import vcsw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int VCI_W     = 6,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  input  logic [VCI_W-1:0]  in_vci,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_we,
  input  logic              cfg_clear,
  input  logic [PORT_W-1:0] cfg_in_port,
  input  logic [VCI_W-1:0]  cfg_in_vci,
  input  logic [PORT_W-1:0] cfg_out_port,
  input  logic [VCI_W-1:0]  cfg_out_vci,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic [VCI_W-1:0]  out_vci,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  drop_count
);

  logic              tbl_hit;
  logic [PORT_W-1:0] tbl_port;
  logic [VCI_W-1:0]  tbl_vci;

  cell_disp_e        s1_disp;
  logic [PORT_W-1:0] s1_port;
  logic [VCI_W-1:0]  s1_vci;
  logic [DATA_W-1:0] s1_data;

  vcsw_circuit_table #(.NUM_PORTS(NUM_PORTS), .VCI_W(VCI_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_clear(cfg_clear),
    .wr_in_port(cfg_in_port), .wr_in_vci(cfg_in_vci),
    .wr_out_port(cfg_out_port), .wr_out_vci(cfg_out_vci),
    .rd_port(in_port), .rd_vci(in_vci),
    .rd_hit(tbl_hit), .rd_out_port(tbl_port), .rd_out_vci(tbl_vci)
  );

  vcsw_lookup_stage #(.PORT_W(PORT_W), .VCI_W(VCI_W), .DATA_W(DATA_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .tbl_hit(tbl_hit),
    .tbl_port(tbl_port), .tbl_vci(tbl_vci), .in_data(in_data),
    .s1_disp(s1_disp), .s1_port(s1_port), .s1_vci(s1_vci), .s1_data(s1_data)
  );

  vcsw_egress_stage #(.PORT_W(PORT_W), .VCI_W(VCI_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_egress (
    .clk(clk), .rst_n(rst_n),
    .s1_disp(s1_disp), .s1_port(s1_port), .s1_vci(s1_vci), .s1_data(s1_data),
    .out_valid(out_valid), .out_port(out_port), .out_vci(out_vci),
    .out_data(out_data), .drop_count(drop_count)
  );

  // R2: a hit leaves exactly two cycles later
  a_r2_hit_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tbl_hit) |=> ##1 out_valid);

  // R5: a miss never produces an output slot
  a_r5_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tbl_hit) |=> ##1 !out_valid);

  // R8: no output without an arrival two cycles earlier
  a_r8_no_phantom_cell: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R3: payload passes through unchanged
  a_r3_payload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tbl_hit) |=> ##1 (out_data == $past(in_data, 2)));

endmodule

// File: tb/vcsw_label_swap_tb.sv
module vcsw_label_swap_tb;

  localparam int NP = 4;
  localparam int PW = 2;
  localparam int VW = 6;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [PW-1:0] in_port = '0;
  logic [VW-1:0] in_vci = '0;
  logic [DW-1:0] in_data = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_clear = 1'b0;
  logic [PW-1:0] cfg_in_port = '0;
  logic [VW-1:0] cfg_in_vci = '0;
  logic [PW-1:0] cfg_out_port = '0;
  logic [VW-1:0] cfg_out_vci = '0;
  logic          out_valid;
  logic [PW-1:0] out_port;
  logic [VW-1:0] out_vci;
  logic [DW-1:0] out_data;
  logic [CW-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  int exp_drops = 0;

  always #10 clk = ~clk;

  vcsw_label_swap #(.NUM_PORTS(NP), .VCI_W(VW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_port(in_port), .in_vci(in_vci), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_clear(cfg_clear),
    .cfg_in_port(cfg_in_port), .cfg_in_vci(cfg_in_vci),
    .cfg_out_port(cfg_out_port), .cfg_out_vci(cfg_out_vci),
    .out_valid(out_valid), .out_port(out_port), .out_vci(out_vci),
    .out_data(out_data), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic note_drop();
    if (exp_drops < (1 << CW) - 1) exp_drops++;
  endtask

  // Expectation for one output slot; drop count checked in every slot
  task automatic check_slot(input string req, input bit hit, input int port,
                            input int vci, input longint data);
    check(out_valid == hit, req, out_valid, hit);
    if (hit) begin
      check(out_port == PW'(port), req, out_port, port);
      check(out_vci == VW'(vci), req, out_vci, vci);
      check(out_data == DW'(data), req, out_data, data);
    end
    check(drop_count == CW'(exp_drops), req, drop_count, exp_drops);
  endtask

  task automatic cfg_write(input int ip, input int iv, input int op, input int ov, input bit clr);
    cfg_we = 1'b1; cfg_clear = clr;
    cfg_in_port = PW'(ip); cfg_in_vci = VW'(iv);
    cfg_out_port = PW'(op); cfg_out_vci = VW'(ov);
    @(negedge clk);
    cfg_we = 1'b0; cfg_clear = 1'b0;
  endtask

  task automatic drive_cell(input int p, input int v, input longint d);
    in_valid = 1'b1; in_port = PW'(p); in_vci = VW'(v); in_data = DW'(d);
  endtask

  // One isolated cell: output visible at the second falling edge
  task automatic send_one(input string req, input int p, input int v, input longint d,
                          input bit hit, input int ep, input int ev);
    drive_cell(p, v, d);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    if (!hit) note_drop();
    check_slot(req, hit, ep, ev, d);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(drop_count == '0, "R1", drop_count, 0);
    send_one("R1", 1, 5, 64'h11, 1'b0, 0, 0);
  endtask

  task automatic t_basic_hit();
    cfg_write(1, 5, 3, 9, 1'b0);
    send_one("R2", 1, 5, 64'hCAFE0001, 1'b1, 3, 9);
    send_one("R3", 1, 5, 64'h5A5A5A5A, 1'b1, 3, 9);
  endtask

  task automatic t_port_in_key();
    cfg_write(2, 5, 0, 33, 1'b0);
    send_one("R4", 2, 5, 64'h200, 1'b1, 0, 33);
    send_one("R4", 1, 5, 64'h100, 1'b1, 3, 9);
    send_one("R4", 0, 5, 64'h000, 1'b0, 0, 0);
  endtask

  task automatic t_overwrite();
    cfg_write(1, 5, 2, 63, 1'b0);
    send_one("R10", 1, 5, 64'hABCD, 1'b1, 2, 63);
  endtask

  task automatic t_invalidate();
    cfg_write(1, 5, 0, 0, 1'b1);
    send_one("R6", 1, 5, 64'h77, 1'b0, 0, 0);
    send_one("R6", 2, 5, 64'h78, 1'b1, 0, 33);
  endtask

  // Write in the arrival cycle: that cell sees old route, next one sees new
  task automatic t_same_cycle_write();
    cfg_write(3, 7, 1, 10, 1'b0);
    drive_cell(3, 7, 64'hA1);
    cfg_we = 1'b1; cfg_clear = 1'b0;
    cfg_in_port = 2'd3; cfg_in_vci = 6'd7; cfg_out_port = 2'd2; cfg_out_vci = 6'd20;
    @(negedge clk);
    cfg_we = 1'b0;
    drive_cell(3, 7, 64'hA2);
    @(negedge clk);
    in_valid = 1'b0;
    check_slot("R7", 1'b1, 1, 10, 64'hA1);
    @(negedge clk);
    check_slot("R7", 1'b1, 2, 20, 64'hA2);
  endtask

  // Back-to-back stream with a miss in the middle
  task automatic t_stream();
    int  sp [5] = '{2, 3, 0, 2, 3};
    int  sv [5] = '{5, 7, 9, 5, 7};
    bit  sh [5] = '{1, 1, 0, 1, 1};
    int  ep [5] = '{0, 2, 0, 0, 2};
    int  ev [5] = '{33, 20, 0, 33, 20};
    for (int t = 0; t < 7; t++) begin
      if (t >= 2) begin
        if (!sh[t-2]) note_drop();
        check_slot("R8", sh[t-2], ep[t-2], ev[t-2], 64'h900 + t - 2);
      end
      if (t < 5) drive_cell(sp[t], sv[t], 64'h900 + t);
      else in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 18; i++) send_one("R9", 0, 60, 64'h1, 1'b0, 0, 0);
    check(drop_count == '1, "R9", drop_count, (1 << CW) - 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_hit();
    t_port_in_key();
    t_overwrite();
    t_invalidate();
    t_same_cycle_write();
    t_stream();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule